// File: doc/BRIEF.md
# Multiplexed CPU Bus Phase Sequencer

This block lets an FPGA share one group of 16 pins with an external CPU by splitting each CPU memory cycle into three timed phases. A rising edge on the CPU's address-latch strobe starts a cycle. First the block treats the pins as inputs and captures the CPU address. Next it opens a control window. In that window the upper half of the pins carries an outbound control byte to an external register, and the lower half carries CPU status bits inward through an external buffer. Last comes a data phase, in which the block either drives read data back to the CPU or captures write data from it.

The block drives the two board-buffer enables and the clock edge of the external control register. Every strobe timing inside a window is a count of fabric clocks. The core logic sees a plain interface: a captured address with a valid pulse, a captured status byte with a valid pulse, a read-data input, a write-data output with a valid pulse, and level inputs for the control lines. One control bit is a heartbeat that toggles after a fixed power-of-two number of address-latch pulses. The strobe inputs are asynchronous and pass through two-flop synchronizers. The pad tristate is formed outside the block from `bus_o` and `bus_oe`.

Top module: `busmux_seq`

## Requirements
- R1: After reset, and whenever no memory cycle is in progress, `bus_oe` is all zeros and `ctrl_rd_en_o`, `adbuf_en_o` and `ctrl_clk_o` are all low.
- R2: `adbuf_en_o` goes high when the address phase starts. The address phase starts 3 clocks after the asynchronous latch input rises: 2 synchronizer flops and 1 edge register. After ADDR_PH clocks, `addr_o` holds `bus_i` and `addr_vld_o` pulses for one clock, in the same clock that the control window opens.
- R3: `ctrl_rd_en_o` stays high for exactly CTRL_PH clocks. `ctrl_rd_en_o` and `adbuf_en_o` are never high together.
- R4: During the control window only the upper half of the bus is driven (`bus_oe` = 16'hFF00 at default width). The upper half carries the control byte: bit 8 = CPU reset, bit 9 = interrupt, bit 10 = non-maskable interrupt, bit 11 = heartbeat LED, bit 12 = disk-activity LED, and bits 15:13 = 0.
- R5: `ctrl_clk_o` rises CLK_RISE clocks after the control window opens and stays high until the window closes.
- R6: On the last clock of the window, the lower half `bus_i[7:0]` is captured into `status_o`, and `status_vld_o` pulses for one clock as the window closes.
- R7: In the data phase, while the synchronized read strobe is low, `bus_oe` is all ones and `bus_o` equals `rd_data_i`. This holds even past the nominal phase length. The pins are released 2 clocks after the read strobe rises.
- R8: In the data phase, `wr_data_o` takes `bus_i` WR_DLY clocks after the synchronized write strobe is seen low. That is WR_DLY+2 clocks after the pin falls. `wr_vld_o` pulses only once per memory cycle.
- R9: The heartbeat bit (control bit 11) toggles on every 2^HB_LOG2-th address-latch rise. It is 0 until the first wrap.
- R10: With no read pending, the data phase ends DATA_PH clocks after it opens and the block returns to idle. A new latch rise during the data phase restarts the address phase at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low reset |
| alatch_i | input | 1 | CPU address-latch strobe, asynchronous |
| rd_n_i | input | 1 | CPU read strobe, active low, asynchronous |
| wr_n_i | input | 1 | CPU write strobe, active low, asynchronous |
| bus_i | input | BUS_W | Pad input value of the shared pins |
| bus_o | output | BUS_W | Pad output value of the shared pins |
| bus_oe | output | BUS_W | Per-pin output enable |
| ctrl_rd_en_o | output | 1 | Enables the status buffer and the control path (control window) |
| adbuf_en_o | output | 1 | Enables the address/data buffer |
| ctrl_clk_o | output | 1 | Clock for the external control register |
| cpu_rst_i | input | 1 | CPU reset level to send |
| cpu_irq_i | input | 1 | Interrupt level to send |
| cpu_nmi_i | input | 1 | Non-maskable interrupt level to send |
| disk_act_i | input | 1 | Disk-activity LED level to send |
| rd_data_i | input | BUS_W | Data returned on CPU reads |
| addr_o | output | BUS_W | Captured CPU address |
| addr_vld_o | output | 1 | One-clock pulse when `addr_o` is updated |
| status_o | output | BUS_W/2 | Captured CPU status byte |
| status_vld_o | output | 1 | One-clock pulse when `status_o` is updated |
| wr_data_o | output | BUS_W | Captured CPU write data |
| wr_vld_o | output | 1 | One-clock pulse when `wr_data_o` is updated |

## Verification
The bench measures the clock distance from the latch edge to the window and from the window start to the register clock. A sequencer with one phase counter off by one would shift the address sample or the status sample onto the wrong bus contents, or would clock the external register before the buffers settle. It holds a read strobe low well past the nominal data-phase length: a design that ends the phase on its own timer would drop read data while the CPU is still sampling. It keeps the write strobe low after the capture, to catch a second write pulse in the same cycle. It runs back-to-back cycles with each new latch edge in the data phase and tracks the heartbeat across its wrap; an off-by-one wrap count or a missed restart shows up as a wrong control byte or a wrong latency.

// File: rtl/busmux_pkg.sv
package busmux_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_CTRL = 2'd2,
      PH_DATA = 2'd3
   } phase_t;

   // Outbound control byte layout, decoded by the external register
   function automatic logic [7:0] pack_ctrl(input logic rst, input logic irq,
                                            input logic nmi, input logic hb,
                                            input logic disk);
      return {3'b000, disk, hb, nmi, irq, rst};
   endfunction

endpackage

// File: rtl/busmux_sync.sv
module busmux_sync #(
   parameter int            W       = 3,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] meta;

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta[b] <= RST_VAL[b];
            q_o[b]  <= RST_VAL[b];
         end else begin
            meta[b] <= d_i[b];
            q_o[b]  <= meta[b];
         end
      end
   end
endmodule

// File: rtl/busmux_hbeat.sv
module busmux_hbeat #(
   parameter int HB_LOG2 = 19
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic led_o
);
   logic [HB_LOG2-1:0] cnt;

   if (HB_LOG2 < 1) begin : g_bad_hb
      $error("busmux_hbeat: HB_LOG2 must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         led_o <= 1'b0;
      end else if (tick_i) begin
         cnt <= cnt + 1'b1;
         if (&cnt) led_o <= ~led_o;
      end
   end
endmodule

// File: rtl/busmux_wrcap.sv
module busmux_wrcap #(
   parameter int BUS_W  = 16,
   parameter int WR_DLY = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             en_i,
   input  logic             wr_n_s_i,
   input  logic [BUS_W-1:0] bus_i,
   output logic [BUS_W-1:0] wr_data_o,
   output logic             wr_vld_o
);
   localparam int DW = $clog2(WR_DLY + 1);

   logic [DW-1:0] dcnt;
   logic          done;

   if (WR_DLY < 1) begin : g_bad_dly
      $error("busmux_wrcap: WR_DLY must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt      <= '0;
         done      <= 1'b0;
         wr_vld_o  <= 1'b0;
         wr_data_o <= '0;
      end else begin
         wr_vld_o <= 1'b0;
         if (arm_i) begin
            dcnt <= '0;
            done <= 1'b0;
         end else if (en_i && !wr_n_s_i && !done) begin
            if (dcnt == DW'(WR_DLY - 1)) begin
               wr_data_o <= bus_i;
               wr_vld_o  <= 1'b1;
               done      <= 1'b1;
            end else begin
               dcnt <= dcnt + 1'b1;
            end
         end
      end
   end

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vld_o |=> !wr_vld_o); // R8
endmodule

// File: rtl/busmux_seq.sv
module busmux_seq
   import busmux_pkg::*;
#(
   parameter int BUS_W    = 16,
   parameter int ADDR_PH  = 3,
   parameter int CTRL_PH  = 3,
   parameter int CLK_RISE = 2,
   parameter int DATA_PH  = 14,
   parameter int WR_DLY   = 3,
   parameter int HB_LOG2  = 19
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alatch_i,
   input  logic               rd_n_i,
   input  logic               wr_n_i,
   input  logic [BUS_W-1:0]   bus_i,
   output logic [BUS_W-1:0]   bus_o,
   output logic [BUS_W-1:0]   bus_oe,
   output logic               ctrl_rd_en_o,
   output logic               adbuf_en_o,
   output logic               ctrl_clk_o,
   input  logic               cpu_rst_i,
   input  logic               cpu_irq_i,
   input  logic               cpu_nmi_i,
   input  logic               disk_act_i,
   input  logic [BUS_W-1:0]   rd_data_i,
   output logic [BUS_W-1:0]   addr_o,
   output logic               addr_vld_o,
   output logic [BUS_W/2-1:0] status_o,
   output logic               status_vld_o,
   output logic [BUS_W-1:0]   wr_data_o,
   output logic               wr_vld_o
);
   localparam int HALF = BUS_W / 2;
   localparam int CW   = $clog2(ADDR_PH + CTRL_PH + DATA_PH + 1);

   if (BUS_W < 16 || (BUS_W % 2) != 0) begin : g_bad_w
      $error("busmux_seq: BUS_W must be even and at least 16");
   end
   if (ADDR_PH < 1 || CTRL_PH < 2 || DATA_PH < 1) begin : g_bad_ph
      $error("busmux_seq: phase lengths too short");
   end
   if (CLK_RISE < 1 || CLK_RISE >= CTRL_PH) begin : g_bad_rise
      $error("busmux_seq: CLK_RISE must fall inside the control window");
   end

   // ---------------- synchronizers and latch edge ----------------
   logic al_s, rd_s, wr_s, al_q, al_rise;

   busmux_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({alatch_i, rd_n_i, wr_n_i}),
      .q_o   ({al_s, rd_s, wr_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) al_q <= 1'b0;
      else        al_q <= al_s;
   end
   assign al_rise = al_s & ~al_q;

   // ---------------- phase sequencer ----------------
   phase_t        ph;
   logic [CW-1:0] cnt;
   logic          addr_last, ctrl_last;

   assign addr_last = (ph == PH_ADDR) && (cnt == CW'(ADDR_PH - 1));
   assign ctrl_last = (ph == PH_CTRL) && (cnt == CW'(CTRL_PH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else if (al_rise) begin
         ph  <= PH_ADDR;
         cnt <= '0;
      end else begin
         unique case (ph)
            PH_ADDR: begin
               if (addr_last) begin ph <= PH_CTRL; cnt <= '0; end
               else cnt <= cnt + 1'b1;
            end
            PH_CTRL: begin
               if (ctrl_last) begin ph <= PH_DATA; cnt <= '0; end
               else cnt <= cnt + 1'b1;
            end
            PH_DATA: begin
               if (cnt >= CW'(DATA_PH - 1)) begin
                  if (rd_s) ph <= PH_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: cnt <= '0;
         endcase
      end
   end

   // ---------------- address and status capture ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o       <= '0;
         addr_vld_o   <= 1'b0;
         status_o     <= '0;
         status_vld_o <= 1'b0;
      end else begin
         addr_vld_o   <= addr_last && !al_rise;
         status_vld_o <= ctrl_last && !al_rise;
         if (addr_last && !al_rise) addr_o   <= bus_i;
         if (ctrl_last && !al_rise) status_o <= bus_i[HALF-1:0];
      end
   end

   // ---------------- heartbeat and write capture ----------------
   logic hb_led;

   busmux_hbeat #(.HB_LOG2(HB_LOG2)) u_hb (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (al_rise),
      .led_o  (hb_led)
   );

   busmux_wrcap #(.BUS_W(BUS_W), .WR_DLY(WR_DLY)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (ctrl_last),
      .en_i      (ph == PH_DATA),
      .wr_n_s_i  (wr_s),
      .bus_i     (bus_i),
      .wr_data_o (wr_data_o),
      .wr_vld_o  (wr_vld_o)
   );

   // ---------------- pad and strobe decode ----------------
   logic [HALF-1:0] ctrl_half;
   assign ctrl_half = HALF'(pack_ctrl(cpu_rst_i, cpu_irq_i, cpu_nmi_i, hb_led, disk_act_i));

   always_comb begin
      ctrl_rd_en_o = (ph == PH_CTRL);
      adbuf_en_o   = (ph == PH_ADDR) || (ph == PH_DATA);
      ctrl_clk_o   = (ph == PH_CTRL) && (cnt >= CW'(CLK_RISE));
      bus_o        = rd_data_i;
      bus_oe       = '0;
      if (ph == PH_CTRL) begin
         bus_o  = {ctrl_half, {HALF{1'b0}}};
         bus_oe = {{HALF{1'b1}}, {HALF{1'b0}}};
      end else if (ph == PH_DATA && !rd_s) begin
         bus_oe = '1;
      end
   end

   // ---------------- assertions ----------------
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE) |-> (bus_oe == '0 && !ctrl_clk_o)); // R1
   AST_ADDR_BEFORE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_rd_en_o) |-> addr_vld_o); // R2
   AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_rd_en_o && adbuf_en_o)); // R3
   AST_STATUS_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rd_en_o |-> (bus_oe[HALF-1:0] == '0)); // R4
   AST_CLK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_clk_o |-> ctrl_rd_en_o); // R5
   AST_STATUS_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      status_vld_o |-> !ctrl_rd_en_o); // R6
   AST_RD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_DATA && !rd_s) |-> (&bus_oe)); // R7
endmodule

// File: tb/sim_busmux_seq.sv
module sim_busmux_seq;
   localparam int BUS_W = 16, ADDR_PH = 3, CTRL_PH = 3, CLK_RISE = 2;
   localparam int DATA_PH = 14, WR_DLY = 3, HB_LOG2 = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alatch = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
   logic [BUS_W-1:0] bus_i = '0, rd_data = '0;
   logic cpu_rst = 1'b0, cpu_irq = 1'b0, cpu_nmi = 1'b0, disk = 1'b0;
   logic [BUS_W-1:0] bus_o, bus_oe, addr_o, wr_data;
   logic [7:0] status_o;
   logic ctrl_rd_en, adbuf_en, ctrl_clk, addr_vld, status_vld, wr_vld;

   int checks = 0, errors = 0, n_rise = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   busmux_seq #(.BUS_W(BUS_W), .ADDR_PH(ADDR_PH), .CTRL_PH(CTRL_PH),
      .CLK_RISE(CLK_RISE), .DATA_PH(DATA_PH), .WR_DLY(WR_DLY),
      .HB_LOG2(HB_LOG2)) u0 (
      .clk(clk), .rst_n(rst_n), .alatch_i(alatch), .rd_n_i(rd_n), .wr_n_i(wr_n),
      .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
      .ctrl_rd_en_o(ctrl_rd_en), .adbuf_en_o(adbuf_en), .ctrl_clk_o(ctrl_clk),
      .cpu_rst_i(cpu_rst), .cpu_irq_i(cpu_irq), .cpu_nmi_i(cpu_nmi),
      .disk_act_i(disk), .rd_data_i(rd_data), .addr_o(addr_o),
      .addr_vld_o(addr_vld), .status_o(status_o), .status_vld_o(status_vld),
      .wr_data_o(wr_data), .wr_vld_o(wr_vld));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_quiet(input string tag);
      chk(bus_oe == '0, {tag, " bus_oe"}, bus_oe, 0);
      chk({ctrl_rd_en, adbuf_en, ctrl_clk} == 3'b000, {tag, " enables"},
          {ctrl_rd_en, adbuf_en, ctrl_clk}, 0);
   endtask

   // One address phase plus control window; returns at the negedge after close
   task automatic t_cycle(input logic [15:0] addr, input logic [15:0] stat,
                          input logic [3:0] ctl);
      int k = 0;
      int j = 0;
      logic [7:0] exp_ctl;
      {cpu_rst, cpu_irq, cpu_nmi, disk} = ctl;
      @(negedge clk);
      bus_i = addr; alatch = 1'b1; n_rise++;
      exp_ctl = {3'b000, disk, 1'((n_rise >> HB_LOG2) & 1), cpu_nmi, cpu_irq, cpu_rst};
      while (!ctrl_rd_en && k < 40) begin
         @(negedge clk); k++;
         if (k == 3) chk(adbuf_en == 1'b1, "R2 addr buffer on", adbuf_en, 1);
      end
      chk(k == ADDR_PH + 3, "R2/R10 latch-to-window clocks", k, ADDR_PH + 3);
      chk(addr_vld && addr_o == addr, "R2 address capture", addr_o, addr);
      chk(adbuf_en == 1'b0, "R3 addr buffer off in window", adbuf_en, 0);
      chk(bus_oe == 16'hFF00, "R4 window drive mask", bus_oe, 16'hFF00);
      chk(bus_o[15:8] == exp_ctl, "R4 control byte", bus_o[15:8], exp_ctl);
      chk(bus_o[11] == exp_ctl[3], "R9 heartbeat bit", bus_o[11], exp_ctl[3]);
      bus_i = stat; alatch = 1'b0;
      while (!ctrl_clk && j < 40) begin @(negedge clk); j++; end
      chk(j == CLK_RISE, "R5 register clock delay", j, CLK_RISE);
      while (ctrl_rd_en && j < 40) begin
         chk(ctrl_clk == 1'b1, "R5 register clock held", ctrl_clk, 1);
         @(negedge clk); j++;
      end
      chk(j == CTRL_PH, "R3 window length", j, CTRL_PH);
      chk(status_vld && status_o == stat[7:0], "R6 status capture", status_o, stat[7:0]);
   endtask

   task automatic t_data_timeout;
      int k = 0;
      while (adbuf_en && k < 100) begin @(negedge clk); k++; end
      chk(k == DATA_PH, "R10 data phase length", k, DATA_PH);
      check_quiet("R1 idle after cycle");
   endtask

   task automatic t_read(input logic [15:0] d);
      rd_n = 1'b0; rd_data = d;
      repeat (3) @(negedge clk);
      chk(bus_oe == 16'hFFFF, "R7 read drive enable", bus_oe, 16'hFFFF);
      chk(bus_o == d, "R7 read data", bus_o, d);
      repeat (DATA_PH + 4) @(negedge clk);
      chk(bus_oe == 16'hFFFF && bus_o == d, "R7 read held past phase", bus_oe, 16'hFFFF);
      rd_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(bus_oe == '0, "R7 read release", bus_oe, 0);
   endtask

   task automatic t_write(input logic [15:0] d);
      int k = 0;
      int extra = 0;
      wr_n = 1'b0; bus_i = d;
      while (!wr_vld && k < 40) begin @(negedge clk); k++; end
      chk(k == WR_DLY + 2, "R8 write capture delay", k, WR_DLY + 2);
      chk(wr_data == d, "R8 write data", wr_data, d);
      repeat (4) begin @(negedge clk); if (wr_vld) extra++; end
      chk(extra == 0, "R8 single write pulse", extra, 0);
      wr_n = 1'b1;
   endtask

   task automatic wait_idle;
      int k = 0;
      while (adbuf_en && k < 100) begin @(negedge clk); k++; end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_quiet("R1 reset state");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_quiet("R1 idle after reset");

      t_cycle(16'h1234, 16'h00A5, 4'b1010);
      t_data_timeout();

      t_cycle(16'hBEEF, 16'h0013, 4'b0101);
      t_read(16'hC0DE);
      wait_idle();

      t_cycle(16'h4000, 16'h001F, 4'b0011);
      t_write(16'h5A3C);
      wait_idle();
      check_quiet("R1 idle after write");

      // back-to-back cycles: each latch rise lands in the data phase (R10, R9 wrap)
      for (int c = 0; c < 14; c++)
         t_cycle(16'h0100 * c + 16'h0011, 16'(c * 7), 4'(c));
      t_data_timeout();

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule